// File: doc/BRIEF.md
# Tagged Multi-Line Receive Silo

This block collects received characters from up to sixteen serial lines into one shared first-in first-out store. Each line's receiver gives a one-cycle strobe with a character and its parity and framing flags. Every stored entry is tagged with the number of the line that sent it and its error flags, so the host can sort the entries after it reads them. The host pops one entry for each read strobe of the receive register. An entry in the read word carries a valid bit, so software can read in a loop until the valid bit is clear.

Each line has a one-entry holding slot in front of the store. An arbiter moves one slot into the store per cycle. The lowest-numbered waiting line goes first. A control/status register holds the interrupt enables, a maintenance (loopback) select and a self-clearing master clear. A programmable fill level drives a storage alarm. That alarm and the non-empty state give two separate interrupt outputs.

Top module: `mux_rx_silo`

## Requirements
- R1: A pop happens only when `rx_rd` is high and the store is not empty. The popped word appears on `rx_word` in the cycle after the strobe. A read strobe while the store is empty makes `rx_word` read 0x0000, and bit 15 is then 0.
- R2: A popped word has bit 15 = 1, bit 14 = overrun, bit 13 = framing error, bit 12 = parity error, bits 11:8 = line number and bits 7:0 = character.
- R3: Entries leave in the order they entered. The store holds at most DEPTH entries, and `fill_level` gives the current count.
- R4: A strobe is taken into the line's slot at the clock edge where it is sampled. The entry reaches the store at the next edge. When several slots wait, one enters per cycle, lowest line number first.
- R5: A slot that reaches a full store is dropped and `fill_level` does not change. The next entry that is accepted has its overrun bit set.
- R6: If a line strobes again while its previous character still waits in its slot, the new character replaces the old one and carries the overrun bit.
- R7: CSR bit 7 reads 1 while the store is not empty. Bit 6 is the receive interrupt enable. `rx_irq` = bit 7 AND bit 6.
- R8: CSR bit 14 reads 1 while the alarm level is non-zero and `fill_level` is at or above it. Bit 12 is its enable, and `stor_irq` = bit 14 AND bit 12. A `lvl_wr` strobe loads the level. The level resets to ALARM_INIT.
- R9: A CSR write with bit 11 set empties the store and the slots. It also clears the overrun memory, the enables and the maintenance bit, returns the level to ALARM_INIT and makes `rx_word` read 0. Bit 11 always reads 0.
- R10: CSR bit 9 is the maintenance select. It drives `loopback_en` and reads back in bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_push | input | NLINES | Per-line character strobe |
| line_char | input | NLINES*8 | Per-line character, line i in bits 8i+7:8i |
| line_perr | input | NLINES | Per-line parity error flag |
| line_ferr | input | NLINES | Per-line framing error flag |
| rx_rd | input | 1 | Receive register read strobe (pop) |
| rx_word | output | 16 | Registered receive word |
| csr_wr | input | 1 | Control/status register write strobe |
| csr_wdata | input | 16 | Control/status write data |
| csr_rdata | output | 16 | Control/status read value |
| lvl_wr | input | 1 | Alarm level write strobe |
| lvl_wdata | input | clog2(DEPTH+1) | Alarm level value |
| fill_level | output | clog2(DEPTH+1) | Current entry count |
| rx_irq | output | 1 | Receive interrupt |
| stor_irq | output | 1 | Storage alarm interrupt |
| loopback_en | output | 1 | Maintenance loopback select to the receivers |

## Verification
The bench builds the block with all sixteen lines, DEPTH = 8 and ALARM_INIT = 4. The shallow store lets a few strobes fill it, so the full-store drop and the overrun bit on the next accepted entry can be tested directly. The full set of lines lets the bench test line 15 tagging and a four-way collision, and with that collision a slot that is overwritten while it waits behind lower lines.

// File: rtl/silo_pkg.sv
package silo_pkg;
  localparam int LINE_W = 4;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              ovr;
    logic              ferr;
    logic              perr;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] ch;
  } silo_entry_t;

  localparam int ENTRY_W = $bits(silo_entry_t);
endpackage

// File: rtl/silo_line_arb.sv
module silo_line_arb
  import silo_pkg::*;
#(
  parameter int NLINES = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic [NLINES-1:0]        push,
  input  logic [NLINES*CHAR_W-1:0] chars,
  input  logic [NLINES-1:0]        perr,
  input  logic [NLINES-1:0]        ferr,
  output logic                     take_valid,
  output silo_entry_t              take_entry
);
  logic [NLINES-1:0] pend;
  logic [NLINES-1:0] grant;
  logic [NLINES-1:0] s_perr, s_ferr, s_ovr;
  logic [CHAR_W-1:0] s_ch [NLINES];
  logic [LINE_W-1:0] sel;

  always_comb begin
    grant = '0;
    sel   = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        grant = {{(NLINES-1){1'b0}}, 1'b1} << i;
        sel   = LINE_W'(i);
      end
    end
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        pend[g]   <= 1'b0;
        s_perr[g] <= 1'b0;
        s_ferr[g] <= 1'b0;
        s_ovr[g]  <= 1'b0;
        s_ch[g]   <= '0;
      end else if (push[g]) begin
        pend[g]   <= 1'b1;
        s_ch[g]   <= chars[g*CHAR_W +: CHAR_W];
        s_perr[g] <= perr[g];
        s_ferr[g] <= ferr[g];
        s_ovr[g]  <= pend[g] & ~grant[g];
      end else if (grant[g]) begin
        pend[g] <= 1'b0;
      end
    end
  end

  assign take_valid      = |pend;
  assign take_entry.ovr  = s_ovr[sel];
  assign take_entry.ferr = s_ferr[sel];
  assign take_entry.perr = s_perr[sel];
  assign take_entry.line = sel;
  assign take_entry.ch   = s_ch[sel];

  p_one_grant_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  p_grant_pending_r4: assert property (@(posedge clk) disable iff (rst)
    ((grant & ~pend) == '0));
endmodule

// File: rtl/silo_ram.sv
module silo_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 15,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_q
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/mux_rx_silo.sv
module mux_rx_silo
  import silo_pkg::*;
#(
  parameter int NLINES     = 16,
  parameter int DEPTH      = 64,
  parameter int ALARM_INIT = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NLINES-1:0]                line_push,
  input  logic [NLINES*8-1:0]              line_char,
  input  logic [NLINES-1:0]                line_perr,
  input  logic [NLINES-1:0]                line_ferr,
  input  logic                             rx_rd,
  output logic [15:0]                      rx_word,
  input  logic                             csr_wr,
  input  logic [15:0]                      csr_wdata,
  output logic [15:0]                      csr_rdata,
  input  logic                             lvl_wr,
  input  logic [$clog2(DEPTH+1)-1:0]       lvl_wdata,
  output logic [$clog2(DEPTH+1)-1:0]       fill_level,
  output logic                             rx_irq,
  output logic                             stor_irq,
  output logic                             loopback_en
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] LVL_INIT = CW'(ALARM_INIT);

  logic              mclr;
  logic              take_valid;
  silo_entry_t       take_entry, wr_entry;
  logic [ENTRY_W-1:0] rd_q;
  logic              full, wr_fire, rd_fire, drop_ovr;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt, cnt_nxt, lvl, lvl_nxt;
  logic              rd_valid, rx_ie, st_ie, maint, rx_flag, stor_flag;

  assign mclr = csr_wr & csr_wdata[11];

  silo_line_arb #(.NLINES(NLINES)) i_arb (
    .clk(clk), .rst(rst), .clr(mclr),
    .push(line_push), .chars(line_char),
    .perr(line_perr), .ferr(line_ferr),
    .take_valid(take_valid), .take_entry(take_entry)
  );

  assign full    = (cnt == FULL_CNT);
  assign wr_fire = take_valid & ~full & ~mclr;
  assign rd_fire = rx_rd & (cnt != '0) & ~mclr;

  always_comb begin
    wr_entry     = take_entry;
    wr_entry.ovr = take_entry.ovr | drop_ovr;
  end

  silo_ram #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) i_ram (
    .clk(clk),
    .wr_en(wr_fire), .wr_addr(wr_ptr), .wr_data(wr_entry),
    .rd_en(rd_fire), .rd_addr(rd_ptr), .rd_q(rd_q)
  );

  always_comb begin
    if (mclr) cnt_nxt = '0;
    else      cnt_nxt = cnt + CW'(wr_fire) - CW'(rd_fire);
    if (mclr)        lvl_nxt = LVL_INIT;
    else if (lvl_wr) lvl_nxt = lvl_wdata;
    else             lvl_nxt = lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      lvl       <= LVL_INIT;
      drop_ovr  <= 1'b0;
      rd_valid  <= 1'b0;
      rx_ie     <= 1'b0;
      st_ie     <= 1'b0;
      maint     <= 1'b0;
      rx_flag   <= 1'b0;
      stor_flag <= 1'b0;
    end else begin
      cnt       <= cnt_nxt;
      lvl       <= lvl_nxt;
      rx_flag   <= (cnt_nxt != '0);
      stor_flag <= (lvl_nxt != '0) && (cnt_nxt >= lvl_nxt);
      if (mclr) begin
        wr_ptr   <= '0;
        rd_ptr   <= '0;
        drop_ovr <= 1'b0;
        rd_valid <= 1'b0;
        rx_ie    <= 1'b0;
        st_ie    <= 1'b0;
        maint    <= 1'b0;
      end else begin
        if (csr_wr) begin
          rx_ie <= csr_wdata[6];
          st_ie <= csr_wdata[12];
          maint <= csr_wdata[9];
        end
        if (wr_fire) begin
          wr_ptr   <= wr_ptr + AW'(1);
          drop_ovr <= 1'b0;
        end else if (take_valid && full) begin
          drop_ovr <= 1'b1;
        end
        if (rx_rd) rd_valid <= rd_fire;
        if (rd_fire) rd_ptr <= rd_ptr + AW'(1);
      end
    end
  end

  assign rx_word     = rd_valid ? {1'b1, rd_q} : 16'h0000;
  assign fill_level  = cnt;
  assign csr_rdata   = {1'b0, stor_flag, 1'b0, st_ie, 2'b00, maint, 1'b0,
                        rx_flag, rx_ie, 6'b000000};
  assign rx_irq      = rx_flag & rx_ie;
  assign stor_irq    = stor_flag & st_ie;
  assign loopback_en = maint;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT);
  p_empty_read_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && cnt == '0 && !csr_wr) |=> (rx_word == 16'h0000));
  p_pop_valid_r2: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && cnt != '0 && !csr_wr) |=> rx_word[15]);
  p_mclr_empties_r9: assert property (@(posedge clk) disable iff (rst)
    mclr |=> (cnt == '0 && !rx_irq && !stor_irq));
  p_alarm_level_r8: assert property (@(posedge clk) disable iff (rst)
    csr_rdata[14] == (lvl != '0 && cnt >= lvl));
endmodule

// File: tb/test_mux_rx_silo.sv
module test_mux_rx_silo;
  localparam int NL = 16;
  localparam int DP = 8;
  localparam int CW = $clog2(DP+1);

  logic clk = 1'b0;
  logic rst;
  logic [NL-1:0]   line_push, line_perr, line_ferr;
  logic [NL*8-1:0] line_char;
  logic            rx_rd, csr_wr, lvl_wr;
  logic [15:0]     rx_word, csr_wdata, csr_rdata;
  logic [CW-1:0]   lvl_wdata, fill_level;
  logic            rx_irq, stor_irq, loopback_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mux_rx_silo #(.NLINES(NL), .DEPTH(DP), .ALARM_INIT(4)) i_mux_rx_silo (
    .clk(clk), .rst(rst), .line_push(line_push), .line_char(line_char),
    .line_perr(line_perr), .line_ferr(line_ferr), .rx_rd(rx_rd),
    .rx_word(rx_word), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata),
    .fill_level(fill_level), .rx_irq(rx_irq), .stor_irq(stor_irq),
    .loopback_en(loopback_en)
  );

  // {ferr, perr, line[3:0], char[7:0]}; expected word = 0x8000 | entry
  localparam logic [13:0] VEC [0:5] = '{
    14'h0_041, 14'h1_F5A, 14'h2_3C3, 14'h3_700, 14'h0_AFF, 14'h1_012
  };

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic set_line(int ln, logic [7:0] ch, logic pe, logic fe);
    line_push[ln] = 1'b1;
    line_char[ln*8 +: 8] = ch;
    line_perr[ln] = pe;
    line_ferr[ln] = fe;
  endtask

  task automatic strobe_end();
    @(negedge clk);
    line_push = '0; line_perr = '0; line_ferr = '0;
  endtask

  task automatic push1(int ln, logic [7:0] ch);
    set_line(ln, ch, 1'b0, 1'b0);
    strobe_end();
  endtask

  task automatic rd(output logic [15:0] w);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    w = rx_word;
  endtask

  task automatic wcsr(logic [15:0] v);
    csr_wr = 1'b1; csr_wdata = v;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    rst = 1'b1; line_push = '0; line_char = '0; line_perr = '0; line_ferr = '0;
    rx_rd = 1'b0; csr_wr = 1'b0; csr_wdata = '0; lvl_wr = 1'b0; lvl_wdata = '0;
    cyc(3);
    rst = 1'b0;
    cyc(1);

    // reset state
    chk("R3 reset fill", 16'(fill_level), 16'h0);
    chk("R7 reset csr", csr_rdata, 16'h0000);
    chk("R1 reset word", rx_word, 16'h0000);

    // R1: empty read
    rd(w);
    chk("R1 empty read", w, 16'h0000);

    // R2/R3: table of vectors, pushed back to back
    for (int i = 0; i < 6; i++) begin
      set_line(int'(VEC[i][11:8]), VEC[i][7:0], VEC[i][12], VEC[i][13]);
      strobe_end();
    end
    cyc(1);
    chk("R3 fill after table", 16'(fill_level), 16'd6);
    chk("R7 rx flag set", 16'(csr_rdata[7]), 16'h1);
    chk("R8 level 4 reached", 16'(csr_rdata[14]), 16'h1);
    for (int i = 0; i < 6; i++) begin
      rd(w);
      chk("R2 table word", w, 16'h8000 | 16'(VEC[i]));
    end
    rd(w);
    chk("R1 drained read", w, 16'h0000);
    chk("R7 rx flag clear", 16'(csr_rdata[7]), 16'h0);

    // R4: simultaneous lines 9 and 2
    set_line(9, 8'h99, 1'b0, 1'b0);
    set_line(2, 8'h22, 1'b0, 1'b0);
    strobe_end();
    chk("R4 none stored yet", 16'(fill_level), 16'd0);
    cyc(1);
    chk("R4 one per cycle", 16'(fill_level), 16'd1);
    cyc(1);
    chk("R4 second next cycle", 16'(fill_level), 16'd2);
    rd(w);
    chk("R4 lower line first", w, 16'h8222);
    rd(w);
    chk("R4 higher line second", w, 16'h8999);

    // R6: line 3 overwritten while waiting
    for (int i = 0; i < 4; i++) set_line(i, 8'(8'h10 + i), 1'b0, 1'b0);
    strobe_end();
    push1(3, 8'h77);
    cyc(3);
    chk("R6 fill four", 16'(fill_level), 16'd4);
    for (int i = 0; i < 3; i++) begin
      rd(w);
      chk("R6 earlier lines", w, 16'h8000 | 16'(i << 8) | 16'(8'h10 + i));
    end
    rd(w);
    chk("R6 replaced char overrun", w, 16'hC377);

    // R5: overflow
    for (int i = 0; i < DP; i++) push1(i, 8'(8'h50 + i));
    cyc(1);
    chk("R3 full", 16'(fill_level), 16'(DP));
    push1(10, 8'hAA);
    cyc(1);
    chk("R5 drop keeps fill", 16'(fill_level), 16'(DP));
    rd(w);
    chk("R3 order head", w, 16'h8050);
    push1(11, 8'hBB);
    cyc(1);
    for (int i = 1; i < DP; i++) begin
      rd(w);
      chk("R3 order", w, 16'h8000 | 16'(i << 8) | 16'(8'h50 + i));
    end
    rd(w);
    chk("R5 next entry overrun", w, 16'hCBBB);

    // R7/R8: interrupts
    lvl_wr = 1'b1; lvl_wdata = 4'd3;
    @(negedge clk);
    lvl_wr = 1'b0;
    wcsr(16'h1040);
    chk("R7 irq empty", 16'(rx_irq), 16'h0);
    push1(4, 8'h01);
    push1(5, 8'h02);
    cyc(1);
    chk("R7 rx irq", 16'(rx_irq), 16'h1);
    chk("R8 below level", 16'(stor_irq), 16'h0);
    push1(6, 8'h03);
    cyc(1);
    chk("R8 at level", 16'(stor_irq), 16'h1);
    chk("R8 csr bits", csr_rdata & 16'h5040, 16'h5040);
    rd(w);
    chk("R8 below again", 16'(stor_irq), 16'h0);
    wcsr(16'h0040);
    push1(7, 8'h04);
    cyc(1);
    chk("R8 flag without enable", {15'h0, csr_rdata[14]}, 16'h1);
    chk("R8 irq disabled", 16'(stor_irq), 16'h0);

    // R10: maintenance
    wcsr(16'h0240);
    chk("R10 loopback", 16'(loopback_en), 16'h1);
    chk("R10 readback", 16'(csr_rdata[9]), 16'h1);

    // R9: master clear
    wcsr(16'h0800);
    chk("R9 fill cleared", 16'(fill_level), 16'h0);
    chk("R9 csr cleared", csr_rdata, 16'h0000);
    chk("R9 loopback off", 16'(loopback_en), 16'h0);
    rd(w);
    chk("R9 empty after clear", w, 16'h0000);
    for (int i = 0; i < 4; i++) push1(i, 8'h33);
    cyc(1);
    chk("R9 level back to init", {15'h0, csr_rdata[14]}, 16'h1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule